// File: doc/BRIEF.md
# Zero-Suppressed Hit Event Formatter

This block sits behind a bank of channel digitisers in a self-triggered front end. For every bunch crossing it takes one beat holding three digitised amplitudes per channel, one from each shaper gain (×2, ×20, ×100). A channel is treated as a hit only when its most sensitive (×100) amplitude lies strictly above a programmable half-MIP threshold. All other channels are dropped on the spot, so only useful data reaches the on-chip store.

For each hit channel the formatter picks the most sensitive gain that is not saturated. It then builds one 32-bit event word that holds:
- the channel number (position);
- the chosen amplitude (energy);
- the crossing identifier (time);
- a gain code.

A free-running crossing counter supplies the identifier. The counter restarts on a train-start strobe.

Hits from one crossing are written one per cycle, lowest channel first, into a 64-entry FIFO. While that scan runs, the crossing input is held off with back-pressure. When the FIFO is full and nothing leaves it in that cycle, a new word is discarded and a drop counter goes up.

Both streams use valid/ready handshakes:
- **Crossing input:** a beat transfers on a clock edge where `xing_valid` and `xing_ready` are both high. `xing_ready` is low while hits of the previous crossing are still being written. The source must hold its beat until it is taken.
- **Event output:** a word leaves on an edge where `evt_valid` and `evt_ready` are both high. While `evt_ready` is low, the word stays stable and valid.

Top module: `hit_event_packer`

## Requirements
- R1: After reset `evt_valid` is 0, `xing_ready` is 1 and `drop_count` is 0.
- R2: A channel produces an event only if its ×100 amplitude is strictly greater than `thresh`. An amplitude equal to `thresh` produces no word.
- R3: The gain code is 2 (×100) if the ×100 amplitude is below 4095. Otherwise it is 1 (×20) if the ×20 amplitude is below 4095. Otherwise it is 0 (×2). The amplitude field carries the sample of the chosen gain, and code 3 is never emitted.
- R4: The event word layout is channel in [31:26], crossing ID in [25:14], amplitude in [13:2] and gain code in [1:0].
- R5: Hits from one crossing leave in ascending channel order.
- R6: The crossing ID is 12 bits.
  - It increments by one per accepted crossing, with or without hits, and wraps from 4095 to 0.
  - A `train_start` pulse without a crossing makes the next accepted crossing ID 0.
  - A `train_start` pulse in the same cycle as an accepted crossing gives that crossing ID 0, and the one after it ID 1.
- R7: After accepting a crossing with H hits, `xing_ready` is low for exactly H cycles.
- R8: While `evt_ready` is low, `evt_valid` stays high and `evt_word` stays unchanged. Words leave in the order they were written.
- R9: The FIFO holds 64 words. A word produced while it is full, with no word leaving in that cycle, is discarded and `drop_count` increases by one (saturating).
- R10: A word produced while the FIFO is full, in the same cycle that a word leaves, is stored and not counted as dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| train_start | input | 1 | Clears the crossing counter |
| thresh | input | 12 | Hit threshold applied to the ×100 amplitude |
| xing_valid | input | 1 | Crossing beat valid |
| xing_ready | output | 1 | Crossing beat accepted when high |
| smp_g2 | input | NCH*12 | ×2 amplitudes, channel c in bits [12c+11:12c] |
| smp_g20 | input | NCH*12 | ×20 amplitudes, same packing |
| smp_g100 | input | NCH*12 | ×100 amplitudes, same packing |
| evt_valid | output | 1 | Event word available |
| evt_ready | input | 1 | Consumer takes the word when high |
| evt_word | output | 32 | Packed event word |
| drop_count | output | DROP_W | Count of discarded event words |

## Verification
Two functions can meet in one clock edge, and the bench forces each collision directly.

**Counter clear against crossing capture.** The counter clear and a crossing capture are made to coincide by raising `train_start` on the very beat that is accepted. The bench judges the result by the crossing IDs of that word and the next one, which must be 0 and then 1.

**FIFO write against FIFO read when full.** The FIFO is filled to 64 with `evt_ready` low. A one-hit crossing is then accepted, and `evt_ready` is raised only for the single cycle in which that hit is written. The outcome is judged at the ports: `drop_count` must be unchanged, exactly 64 words must drain, and the new hit must be the last word out.

// File: rtl/hep_pkg.sv
package hep_pkg;
  localparam int CH_W   = 6;
  localparam int AMP_W  = 12;
  localparam int XID_W  = 12;
  localparam int GAIN_W = 2;
  localparam int WORD_W = CH_W + XID_W + AMP_W + GAIN_W;
  localparam logic [AMP_W-1:0] SAT_CODE = '1;

  typedef enum logic [GAIN_W-1:0] {
    GAIN_X2   = 2'd0,
    GAIN_X20  = 2'd1,
    GAIN_X100 = 2'd2,
    GAIN_RSVD = 2'd3
  } gain_e;

  typedef struct packed {
    logic [CH_W-1:0]  ch;
    logic [XID_W-1:0] xid;
    logic [AMP_W-1:0] amp;
    gain_e            gain;
  } evt_word_t;
endpackage

// File: rtl/hep_gain_pick.sv
module hep_gain_pick
  import hep_pkg::*;
#(
  parameter int NCH = 16
) (
  input  logic [NCH*AMP_W-1:0]        g2,
  input  logic [NCH*AMP_W-1:0]        g20,
  input  logic [NCH*AMP_W-1:0]        g100,
  input  logic [AMP_W-1:0]            thr,
  output logic [NCH-1:0]              hit,
  output logic [NCH-1:0][AMP_W-1:0]   amp_sel,
  output logic [NCH-1:0][GAIN_W-1:0]  gain_sel
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [AMP_W-1:0] s_lo, s_mid, s_hi;
    assign s_lo  = g2[c*AMP_W +: AMP_W];
    assign s_mid = g20[c*AMP_W +: AMP_W];
    assign s_hi  = g100[c*AMP_W +: AMP_W];
    assign hit[c] = s_hi > thr;

    always_comb begin
      if (s_hi != SAT_CODE) begin
        amp_sel[c]  = s_hi;
        gain_sel[c] = GAIN_X100;
      end else if (s_mid != SAT_CODE) begin
        amp_sel[c]  = s_mid;
        gain_sel[c] = GAIN_X20;
      end else begin
        amp_sel[c]  = s_lo;
        gain_sel[c] = GAIN_X2;
      end
    end
  end
endmodule

// File: rtl/hep_xing_count.sv
module hep_xing_count
  import hep_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             advance,
  output logic [XID_W-1:0] cur
);
  logic [XID_W-1:0] cnt;

  assign cur = clear ? '0 : cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (advance) cnt <= cur + 1'b1;
    else              cnt <= cur;
  end
endmodule

// File: rtl/hep_scan.sv
module hep_scan
  import hep_pkg::*;
#(
  parameter int NCH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load,
  input  logic [NCH-1:0]             hit_in,
  input  logic [NCH-1:0][AMP_W-1:0]  amp_in,
  input  logic [NCH-1:0][GAIN_W-1:0] gain_in,
  input  logic [XID_W-1:0]           xid_in,
  output logic                       busy,
  output logic                       push,
  output evt_word_t                  word
);
  localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1;

  logic [NCH-1:0]             mask;
  logic [NCH-1:0]             clr;
  logic [IDX_W-1:0]           idx;
  logic [NCH-1:0][AMP_W-1:0]  amp_r;
  logic [NCH-1:0][GAIN_W-1:0] gain_r;
  logic [XID_W-1:0]           xid_r;

  always_comb begin
    idx = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (mask[i]) idx = IDX_W'(i);
    end
  end

  always_comb begin
    clr      = '0;
    clr[idx] = 1'b1;
  end

  assign busy = |mask;
  assign push = busy;

  always_comb begin
    word.ch   = CH_W'(idx);
    word.xid  = xid_r;
    word.amp  = amp_r[idx];
    word.gain = gain_e'(gain_r[idx]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mask <= '0;
    else if (load) mask <= hit_in;
    else if (busy) mask <= mask & ~clr;
  end

  always_ff @(posedge clk) begin
    if (load) begin
      amp_r  <= amp_in;
      gain_r <= gain_in;
      xid_r  <= xid_in;
    end
  end
endmodule

// File: rtl/hep_fifo.sv
module hep_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         full,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;

  assign full    = cnt == (AW+1)'(DEPTH);
  assign empty   = cnt == '0;
  assign rd_data = mem[rp];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (wr_en) wp <= wp + 1'b1;
      if (rd_en) rp <= rp + 1'b1;
      case ({wr_en, rd_en})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/hit_event_packer.sv
module hit_event_packer
  import hep_pkg::*;
#(
  parameter int NCH        = 16,
  parameter int FIFO_DEPTH = 64,
  parameter int DROP_W     = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  train_start,
  input  logic [AMP_W-1:0]      thresh,
  input  logic                  xing_valid,
  output logic                  xing_ready,
  input  logic [NCH*AMP_W-1:0]  smp_g2,
  input  logic [NCH*AMP_W-1:0]  smp_g20,
  input  logic [NCH*AMP_W-1:0]  smp_g100,
  output logic                  evt_valid,
  input  logic                  evt_ready,
  output logic [WORD_W-1:0]     evt_word,
  output logic [DROP_W-1:0]     drop_count
);
  logic [NCH-1:0]             hit;
  logic [NCH-1:0][AMP_W-1:0]  amp_sel;
  logic [NCH-1:0][GAIN_W-1:0] gain_sel;
  logic [XID_W-1:0]           xid_now;
  logic                       accept, busy, push;
  evt_word_t                  word;
  logic                       fifo_full, fifo_empty, fifo_pop, fifo_wr;

  assign xing_ready = !busy;
  assign accept     = xing_valid && xing_ready;

  hep_gain_pick #(.NCH(NCH)) u_pick (
    .g2(smp_g2), .g20(smp_g20), .g100(smp_g100), .thr(thresh),
    .hit(hit), .amp_sel(amp_sel), .gain_sel(gain_sel)
  );

  hep_xing_count u_xid (
    .clk(clk), .rst_n(rst_n), .clear(train_start), .advance(accept), .cur(xid_now)
  );

  hep_scan #(.NCH(NCH)) u_scan (
    .clk(clk), .rst_n(rst_n), .load(accept), .hit_in(hit), .amp_in(amp_sel),
    .gain_in(gain_sel), .xid_in(xid_now), .busy(busy), .push(push), .word(word)
  );

  assign fifo_pop = evt_ready && !fifo_empty;
  assign fifo_wr  = push && (!fifo_full || fifo_pop);

  hep_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .wr_en(fifo_wr), .wr_data(word),
    .rd_en(fifo_pop), .rd_data(evt_word), .full(fifo_full), .empty(fifo_empty)
  );

  assign evt_valid = !fifo_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      drop_count <= '0;
    else if (push && !fifo_wr && drop_count != '1)
      drop_count <= drop_count + 1'b1;
  end
endmodule

// File: rtl/hep_chk.sv
module hep_chk #(
  parameter int DROP_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              evt_valid,
  input logic              evt_ready,
  input logic [31:0]       evt_word,
  input logic [DROP_W-1:0] drop_count,
  input logic              fifo_full,
  input logic              fifo_pop
);
  // R3
  gain_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> evt_word[1:0] != 2'd3);

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid && !evt_ready |=> evt_valid && $stable(evt_word));

  // R9
  drop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (drop_count == $past(drop_count)) || (drop_count == $past(drop_count) + 1'b1));

  // R10
  drop_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_count != $past(drop_count)) |-> $past(fifo_full && !fifo_pop));
endmodule

bind hit_event_packer hep_chk #(.DROP_W(DROP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_ready(evt_ready),
  .evt_word(evt_word), .drop_count(drop_count), .fifo_full(fifo_full),
  .fifo_pop(fifo_pop)
);

// File: tb/hit_event_packer_test.sv
module hit_event_packer_test;
  localparam int NCH = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic train_start = 1'b0;
  logic [11:0] thresh = 12'd100;
  logic xing_valid = 1'b0;
  logic xing_ready;
  logic [NCH*12-1:0] smp_g2 = '0, smp_g20 = '0, smp_g100 = '0;
  logic evt_valid;
  logic evt_ready = 1'b0;
  logic [31:0] evt_word;
  logic [15:0] drop_count;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  hit_event_packer uut (
    .clk(clk), .rst_n(rst_n), .train_start(train_start), .thresh(thresh),
    .xing_valid(xing_valid), .xing_ready(xing_ready), .smp_g2(smp_g2),
    .smp_g20(smp_g20), .smp_g100(smp_g100), .evt_valid(evt_valid),
    .evt_ready(evt_ready), .evt_word(evt_word), .drop_count(drop_count)
  );

  function automatic logic [31:0] mk(int ch, int xid, int amp, int g);
    return {6'(ch), 12'(xid), 12'(amp), 2'(g)};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_samples();
    smp_g2 = '0; smp_g20 = '0; smp_g100 = '0;
  endtask

  task automatic set_ch(input int ch, input int a2, input int a20, input int a100);
    smp_g2[ch*12 +: 12]   = 12'(a2);
    smp_g20[ch*12 +: 12]  = 12'(a20);
    smp_g100[ch*12 +: 12] = 12'(a100);
  endtask

  task automatic pulse_train();
    @(negedge clk) train_start = 1'b1;
    @(negedge clk) train_start = 1'b0;
  endtask

  // returns at the first falling edge after the accepting edge
  task automatic send(input bit ts);
    @(negedge clk);
    xing_valid = 1'b1;
    train_start = ts;
    while (!xing_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    xing_valid = 1'b0;
    train_start = 1'b0;
  endtask

  task automatic pop(output logic [31:0] w);
    @(negedge clk);
    while (!evt_valid) @(negedge clk);
    w = evt_word;
    evt_ready = 1'b1;
    @(negedge clk);
    evt_ready = 1'b0;
  endtask

  task automatic expect_word(input logic [31:0] exp, input string req);
    logic [31:0] w;
    pop(w);
    chk(w == exp, req, w, exp);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(evt_valid == 1'b0, "R1 evt_valid", 32'(evt_valid), 0);
    chk(xing_ready == 1'b1, "R1 xing_ready", 32'(xing_ready), 1);
    chk(drop_count == 0, "R1 drop_count", 32'(drop_count), 0);
  endtask

  task automatic t_single();
    pulse_train();
    clear_samples();
    set_ch(5, 10, 50, 300);
    send(0);
    expect_word(mk(5, 0, 300, 2), "R4 single hit layout");
  endtask

  task automatic t_gain();
    pulse_train();
    clear_samples();
    set_ch(1, 20, 1000, 4095);
    set_ch(2, 77, 4095, 4095);
    set_ch(3, 4095, 4095, 4095);
    send(0);
    expect_word(mk(1, 0, 1000, 1), "R3 x100 saturated picks x20");
    expect_word(mk(2, 0, 77, 0), "R3 x20 saturated picks x2");
    expect_word(mk(3, 0, 4095, 0), "R3 all saturated picks x2");
  endtask

  task automatic t_thresh();
    pulse_train();
    clear_samples();
    set_ch(4, 5, 30, 100);
    set_ch(6, 5, 30, 101);
    send(0);
    expect_word(mk(6, 0, 101, 2), "R2 above threshold kept");
    repeat (3) @(negedge clk);
    chk(evt_valid == 1'b0, "R2 at-threshold channel suppressed", 32'(evt_valid), 0);
  endtask

  task automatic t_order();
    pulse_train();
    clear_samples();
    set_ch(14, 1, 1, 514);
    set_ch(3, 1, 1, 503);
    set_ch(9, 1, 1, 509);
    send(0);
    for (int k = 0; k < 3; k++) begin
      chk(xing_ready == 1'b0, "R7 ready low while scanning", 32'(xing_ready), 0);
      @(negedge clk);
    end
    chk(xing_ready == 1'b1, "R7 ready back after H cycles", 32'(xing_ready), 1);
    expect_word(mk(3, 0, 503, 2), "R5 order first");
    expect_word(mk(9, 0, 509, 2), "R5 order second");
    expect_word(mk(14, 0, 514, 2), "R5 order third");
  endtask

  task automatic t_xid();
    pulse_train();
    clear_samples();
    send(0);
    set_ch(0, 1, 1, 200);
    send(0);
    clear_samples();
    set_ch(2, 1, 1, 202);
    send(1);
    clear_samples();
    set_ch(7, 1, 1, 207);
    send(0);
    expect_word(mk(0, 1, 200, 2), "R6 empty crossing advances ID");
    expect_word(mk(2, 0, 202, 2), "R6 train_start with crossing gives 0");
    expect_word(mk(7, 1, 207, 2), "R6 next after same-cycle clear is 1");
  endtask

  task automatic t_wrap();
    pulse_train();
    clear_samples();
    @(negedge clk) xing_valid = 1'b1;
    repeat (4095) @(negedge clk);
    xing_valid = 1'b0;
    set_ch(1, 1, 1, 301);
    send(0);
    send(0);
    expect_word(mk(1, 4095, 301, 2), "R6 ID reaches 4095");
    expect_word(mk(1, 0, 301, 2), "R6 ID wraps to 0");
  endtask

  task automatic t_hold();
    logic [31:0] e;
    pulse_train();
    clear_samples();
    set_ch(2, 1, 1, 222);
    send(0);
    e = mk(2, 0, 222, 2);
    repeat (2) @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      chk(evt_valid && evt_word == e, "R8 word held while stalled", evt_word, e);
      @(negedge clk);
    end
    expect_word(e, "R8 held word delivered");
  endtask

  task automatic fill64(input int amp);
    clear_samples();
    for (int c = 0; c < NCH; c++) set_ch(c, 1, 1, amp);
    for (int k = 0; k < 4; k++) send(0);
  endtask

  task automatic drain(output int n, output logic [31:0] first, output logic [31:0] last);
    logic [31:0] w;
    n = 0;
    first = '0;
    last = '0;
    @(negedge clk);
    while (evt_valid) begin
      pop(w);
      if (n == 0) first = w;
      last = w;
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_overflow();
    int n;
    logic [31:0] f, l;
    pulse_train();
    fill64(200);
    clear_samples();
    for (int c = 0; c < 3; c++) set_ch(c, 1, 1, 400);
    send(0);
    repeat (5) @(negedge clk);
    chk(drop_count == 16'd3, "R9 three drops counted", 32'(drop_count), 3);
    drain(n, f, l);
    chk(n == 64, "R9 depth 64", 32'(n), 64);
    chk(f == mk(0, 0, 200, 2), "R8 fifo order first", f, mk(0, 0, 200, 2));
    chk(l == mk(15, 3, 200, 2), "R9 last stored before drops", l, mk(15, 3, 200, 2));
  endtask

  task automatic t_pop_full();
    int n;
    logic [31:0] f, l;
    pulse_train();
    fill64(250);
    clear_samples();
    set_ch(0, 1, 1, 333);
    send(0);
    evt_ready = 1'b1;
    @(negedge clk);
    evt_ready = 1'b0;
    repeat (3) @(negedge clk);
    chk(drop_count == 16'd3, "R10 no drop on pop while full", 32'(drop_count), 3);
    drain(n, f, l);
    chk(n == 64, "R10 count after write-with-pop", 32'(n), 64);
    chk(l == mk(0, 4, 333, 2), "R10 new word stored last", l, mk(0, 4, 333, 2));
  endtask

  initial begin
    t_reset();
    t_single();
    t_gain();
    t_thresh();
    t_order();
    t_xid();
    t_wrap();
    t_hold();
    t_overflow();
    t_pop_full();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule